// File: doc/BRIEF.md
# Four-Player Quiz Lockout Arbiter

This block settles who answers first in a four-contestant quiz round. Every contestant has one push button, and a host control opens and closes each round. While the host control is held low the round is cleared. Once it goes high, the block watches the synchronized buttons. The first sample that shows exactly one button pressed names that contestant the winner and locks the round. From then on, button activity changes nothing until the host pulls the control low again.

The winner is given on a one-hot vector, and a matching indicator LED stays lit. An active-low seven-segment digit shows the winner's number from 1 to 4. The digit shows 0 while the host holds the round cleared, and it is blank while the round is open with no winner yet. Each raw button passes through a two-flop synchronizer before arbitration. The winner register loads on a rising clock edge.

Top module: `quiz_arbiter`

## Requirements
- R1: A rising clock edge that samples host_n low clears the winner vector, the LEDs and the lock.
- R2: Whenever host_n is low, seg_n shows the digit 0, which is 7'h40. This follows host_n without waiting for a clock edge.
- R3: Contestant i (0..3) drives btn[i]. If btn[i] alone goes high and stays stable from before clock edge k, then win[i] is set after edge k+2. The edge count is set by the two synchronizer stages.
- R4: The winner vector win never has more than one bit set.
- R5: A synchronized sample with two or more buttons pressed names no winner. The round stays open until a sample shows exactly one button pressed.
- R6: Once a winner is latched, win stays the same whatever the buttons do, until host_n is sampled low.
- R7: led equals win on every cycle. The LED of the winner lights and stays lit until the host clears the round.
- R8: seg_n is active-low, with bit 6 driving segment g down to bit 0 driving segment a. With host_n high, seg_n shows the number of the winner: 1 is 7'h79, 2 is 7'h24, 3 is 7'h30 and 4 is 7'h19. With host_n high and no winner, seg_n is blank, 7'h7F.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| host_n | input | 1 | Host control; low holds the round cleared, high opens it |
| btn | input | 4 | Raw contestant buttons, active high, bit i is contestant i+1 |
| win | output | 4 | One-hot winner vector, zero when nobody has won |
| led | output | 4 | Contestant indicator LEDs, lit for the winner |
| seg_n | output | 7 | Active-low segments, bit 6 = g to bit 0 = a |

## Verification
The hardest case to reach is a multi-press sample followed by a single press. This is the case where two contestants press within the same clock and the round must stay open. Only the synchronized sample counts, so the stimulus sets several buttons in one cycle and holds them. It then releases all but one, and checks that the winner appears exactly two edges after the single-button sample enters the synchronizer. One-cycle button pulses and pseudo-random button traffic after lock-out also go through the per-cycle reference model. This shows that late presses and presses that overlap a host reset leave the latched winner alone.

// File: rtl/quiz_pkg.sv
package quiz_pkg;

  typedef logic [6:0] seg_t;

  localparam seg_t SEG_BLANK = 7'h7F;

  // Active-low segment pattern for a decimal digit, bit 6 = g ... bit 0 = a.
  function automatic seg_t digit_segs(input int unsigned d);
    seg_t s;
    case (d)
      0:       s = 7'h40;
      1:       s = 7'h79;
      2:       s = 7'h24;
      3:       s = 7'h30;
      4:       s = 7'h19;
      5:       s = 7'h12;
      6:       s = 7'h02;
      7:       s = 7'h78;
      8:       s = 7'h00;
      9:       s = 7'h10;
      default: s = SEG_BLANK;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             clr,
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] synced
);

  localparam int unsigned LAST = STAGES - 1;

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
      if (clr) chain_q <= '0;
      else     chain_q <= {chain_q[STAGES-2:0], raw[g]};
    end

    assign synced[g] = chain_q[LAST];
  end

endmodule

// File: rtl/lock_arbiter.sv
module lock_arbiter #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             host_n,
  input  logic [WIDTH-1:0] req,
  output logic [WIDTH-1:0] win,
  output logic             locked
);

  localparam int unsigned CW = $clog2(WIDTH + 1);

  function automatic logic [CW-1:0] count_set(input logic [WIDTH-1:0] v);
    logic [CW-1:0] n;
    n = '0;
    for (int i = 0; i < WIDTH; i++) n = n + CW'(v[i]);
    return n;
  endfunction

  logic [WIDTH-1:0] win_q;
  logic             lock_q;
  logic [CW-1:0]    req_count;
  logic             single_req;
  logic             grant_take;

  assign req_count  = count_set(req);
  assign single_req = (req_count == CW'(1));
  assign grant_take = !lock_q && single_req;

  always_ff @(posedge clk) begin
    if (!host_n) begin
      win_q  <= '0;
      lock_q <= 1'b0;
    end else if (grant_take) begin
      win_q  <= req;
      lock_q <= 1'b1;
    end
  end

  assign win    = win_q;
  assign locked = lock_q;

  // R3
  single_grant_chk: assert property (@(posedge clk) disable iff (!host_n)
    (!lock_q && $onehot(req)) |=> (win_q == $past(req)));

  // R5
  multi_press_chk: assert property (@(posedge clk) disable iff (!host_n)
    (!lock_q && ($countones(req) > 1)) |=> !lock_q);

  // R4
  win_onehot0_chk: assert property (@(posedge clk) disable iff (!host_n)
    $onehot0(win_q));

endmodule

// File: rtl/seg_display.sv
module seg_display
  import quiz_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic             host_n,
  input  logic [WIDTH-1:0] win,
  output seg_t             seg_n
);

  function automatic int unsigned player_number(input logic [WIDTH-1:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < WIDTH; i++) if (v[i]) n = i + 1;
    return n;
  endfunction

  always_comb begin
    if (!host_n)        seg_n = digit_segs(0);
    else if (win == '0) seg_n = SEG_BLANK;
    else                seg_n = digit_segs(player_number(win));
  end

endmodule

// File: rtl/quiz_arbiter.sv
module quiz_arbiter #(
  parameter int unsigned N_PLAYERS   = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 host_n,
  input  logic [N_PLAYERS-1:0] btn,
  output logic [N_PLAYERS-1:0] win,
  output logic [N_PLAYERS-1:0] led,
  output logic [6:0]           seg_n
);

  logic [N_PLAYERS-1:0] btn_s;
  logic                 round_locked;

  btn_sync #(.WIDTH(N_PLAYERS), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .clr    (!host_n),
    .raw    (btn),
    .synced (btn_s)
  );

  lock_arbiter #(.WIDTH(N_PLAYERS)) u_arb (
    .clk    (clk),
    .host_n (host_n),
    .req    (btn_s),
    .win    (win),
    .locked (round_locked)
  );

  seg_display #(.WIDTH(N_PLAYERS)) u_seg (
    .host_n (host_n),
    .win    (win),
    .seg_n  (seg_n)
  );

  assign led = win;

  // R6
  hold_winner_chk: assert property (@(posedge clk) disable iff (!host_n)
    round_locked |=> $stable(win));

  // R8
  blank_display_chk: assert property (@(posedge clk) disable iff (!host_n)
    (win == '0) == (seg_n == 7'h7F));

endmodule

// File: tb/quiz_arbiter_test.sv
module quiz_arbiter_test;

  logic       clk = 1'b0;
  logic       host_n = 1'b0;
  logic [3:0] btn = 4'h0;
  logic [3:0] win, led;
  logic [6:0] seg_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  int unsigned m_s1 = 0, m_s2 = 0, m_win = 0;
  bit m_lock = 0;

  always #5 clk = ~clk;

  quiz_arbiter uut (
    .clk(clk), .host_n(host_n), .btn(btn),
    .win(win), .led(led), .seg_n(seg_n)
  );

  function automatic int ones(input int unsigned v);
    int c = 0;
    for (int i = 0; i < 4; i++) if (v[i]) c++;
    return c;
  endfunction

  // expected segments built from the lit-segment letters, then inverted
  function automatic logic [6:0] expect_seg(input int d);
    string lit;
    logic [6:0] on;
    case (d)
      0: lit = "abcdef";
      1: lit = "bc";
      2: lit = "abdeg";
      3: lit = "abcdg";
      4: lit = "bcfg";
      default: lit = "";
    endcase
    on = '0;
    for (int i = 0; i < lit.len(); i++) on[lit[i] - "a"] = 1'b1;
    return ~on;
  endfunction

  task automatic check(input string req, input int unsigned act, input int unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic h, input logic [3:0] b);
    int d;
    host_n = h;
    btn    = b;
    @(posedge clk);
    if (!h) begin
      m_s1 = 0; m_s2 = 0; m_win = 0; m_lock = 0;
    end else begin
      if (!m_lock && ones(m_s2) == 1) begin
        m_win = m_s2; m_lock = 1;
      end
      m_s2 = m_s1;
      m_s1 = b;
    end
    @(negedge clk);
    if (!h)          check("R1", win, m_win);
    else if (m_lock) check("R6", win, m_win);
    else             check("R3", win, m_win);
    check("R7", led, m_win);
    check("R4", (ones(win) <= 1), 1);
    d = 0;
    for (int i = 0; i < 4; i++) if (m_win[i]) d = i + 1;
    if (!h)              check("R2", seg_n, expect_seg(0));
    else if (m_win == 0) check("R8", seg_n, expect_seg(-1));
    else                 check("R8", seg_n, expect_seg(d));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] lfsr;
    @(negedge clk);
    // reset state
    repeat (3) cyc(1'b0, 4'h0);
    check("R1", win, 0);
    check("R2", seg_n, 7'h40);
    // open round, nobody pressing: blank
    repeat (3) cyc(1'b1, 4'h0);
    check("R8", seg_n, 7'h7F);
    // contestant 2 presses: win on third edge
    cyc(1'b1, 4'h2);
    check("R3", win, 0);
    cyc(1'b1, 4'h2);
    check("R3", win, 0);
    cyc(1'b1, 4'h2);
    check("R3", win, 4'h2);
    check("R8", seg_n, 7'h24);
    // later presses ignored
    cyc(1'b1, 4'h1); cyc(1'b1, 4'h8); cyc(1'b1, 4'hF); cyc(1'b1, 4'h4);
    repeat (3) cyc(1'b1, 4'h0);
    check("R6", win, 4'h2);
    check("R7", led, 4'h2);
    // host clears; display shows 0 combinationally
    host_n = 1'b0;
    #1 check("R2", seg_n, 7'h40);
    repeat (2) cyc(1'b0, 4'h0);
    check("R1", win, 0);
    // simultaneous presses: no winner, then single press wins
    repeat (5) cyc(1'b1, 4'h5);
    check("R5", win, 0);
    check("R5", seg_n, 7'h7F);
    repeat (4) cyc(1'b1, 4'h4);
    check("R5", win, 4'h4);
    check("R8", seg_n, 7'h30);
    repeat (2) cyc(1'b0, 4'h0);
    // one-cycle pulse from contestant 4
    cyc(1'b1, 4'h8);
    repeat (3) cyc(1'b1, 4'h0);
    check("R3", win, 4'h8);
    check("R8", seg_n, 7'h19);
    repeat (2) cyc(1'b0, 4'h0);
    // contestant 1
    repeat (4) cyc(1'b1, 4'h1);
    check("R8", seg_n, 7'h79);
    // pseudo-random traffic with occasional host resets
    lfsr = 16'hACE1;
    for (int n = 0; n < 2000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc((lfsr[15:12] != 4'h0), lfsr[3:0] & lfsr[7:4]);
    end
    finish_run();
  end

endmodule